// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block collects a parameterised number of external interrupt pins (1 to 32) and turns each one into an active-high interrupt request toward a processor. Every pin is first brought into the clock domain through a synchronizer chain. A per-pin sense field then picks which conditions latch an event: low level, high level, falling edge, rising edge, or any mix of these. Setting both edge bits catches either edge.

Latched events collect in a detect word that software clears by writing ones. A separate enable mask, with its own set and clear locations, decides which latched events reach the request outputs. A read-only location reports the enabled, pending requests, and a monitor location shows the synchronized pin levels. Software reaches everything through a single 32-bit register port. Reads are combinational on the address, and writes take effect on the clock edge where the write strobe is high.

Top module: `xirq_ctrl`

## Requirements
- R1: NUM_IN (1 to 32) sets the number of pins, and pin n owns bit n of every status, mask and monitor word. Bits at or above NUM_IN read 0. Configuration writes to an index at or above NUM_IN are dropped and read back 0. Unmapped offsets read 0.
- R2: The configuration word of pin n sits at byte offset 0x180 + 4*n. A write stores bits [5:0] as the sense field. Reads return that field with bits [31:6] at 0.
- R3: Sense bit 0 latches while the pin is low and bit 1 while it is high. Bit 2 latches on a falling edge and bit 3 on a rising edge, so 0x0C catches both edges. Set bits combine by OR. Bits 4 and 5 have no effect, and a field of 0 never latches anything.
- R4: Each pin passes two synchronizer flops. A change on the pin shows in the detect word three clock edges later, and one edge latches the detect bit only once. Clearing the bit while the pin holds its new level leaves it clear.
- R5: In a level mode the detect bit is set again on every clock while the level holds. A clear only sticks once the pin is released.
- R6: The detect word at offset 0x100 reads the latched events. Writing 1 to a bit clears it, and writing 0 leaves it as it is.
- R7: Writing ones to offset 0x08 sets enable bits, and writing ones to offset 0x04 clears them. Reading 0x04 returns the enable mask, and reading 0x08 returns 0.
- R8: Offset 0x00 reads detect AND enable and ignores writes.
- R9: Offset 0x104 reads the synchronized pin levels, two clock edges after a pin change.
- R10: req_o[n] is a flop holding detect bit n AND enable bit n, one clock edge behind those two bits.
- R11: When a set condition and a clear write hit the same detect bit in the same cycle, the bit ends set.
- R12: After reset, the enable mask, detect word, request outputs and all configuration words are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_IN | External interrupt pins, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| req_o | output | NUM_IN | Interrupt requests, active high, registered |

## Verification
Two things can land on one detect bit in the same cycle: a new event and a software write-1 clear. The bench provokes this by holding a pin at the level its sense field selects and clearing the bit while the level stays. It repeats the same clear after every phase of a sweep over all 64 sense-field values, with low, high, rising and falling stimulus on a low pin and on the top pin. The bench judges the result from the detect word read back after the clear. Only level bits may survive, and edge bits must stay clear until the next transition. Expected words come from the sense-field bits and the pin history.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
   localparam int DATA_W  = 32;
   localparam int SENSE_W = 6;

   // register byte offsets
   localparam int OFF_REQ_STAT = 'h000;
   localparam int OFF_EN_CLR   = 'h004;
   localparam int OFF_EN_SET   = 'h008;
   localparam int OFF_DETECT   = 'h100;
   localparam int OFF_LEVEL    = 'h104;
   localparam int OFF_CFG_BASE = 'h180;

   // sense field bit positions
   localparam int SNS_LOW  = 0;
   localparam int SNS_HIGH = 1;
   localparam int SNS_FALL = 2;
   localparam int SNS_RISE = 3;

   function automatic logic sense_hit(input logic [SENSE_W-1:0] mode,
                                      input logic cur, input logic prv);
      return (mode[SNS_LOW]  & ~cur)        |
             (mode[SNS_HIGH] &  cur)        |
             (mode[SNS_FALL] &  prv & ~cur) |
             (mode[SNS_RISE] & ~prv &  cur);
   endfunction
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[0] <= '0;
      else        stg_q[0] <= d_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg_q[s] <= '0;
         else        stg_q[s] <= stg_q[s-1];
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/xirq_chan.sv
module xirq_chan
   import xirq_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lvl_i,
   input  logic [SENSE_W-1:0] sense_i,
   input  logic               clr_i,
   input  logic               en_i,
   output logic               det_o,
   output logic               req_o
);
   logic prev_q, det_q, req_q, set_evt;
   logic unused_sense;

   assign unused_sense = ^sense_i[SENSE_W-1:4];
   assign set_evt      = sense_hit(sense_i, lvl_i, prev_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         det_q  <= 1'b0;
         req_q  <= 1'b0;
      end else begin
         prev_q <= lvl_i;
         det_q  <= set_evt | (det_q & ~clr_i);
         req_q  <= det_q & en_i;
      end
   end

   assign det_o = det_q;
   assign req_o = req_q;

   // R11: a new event wins over a simultaneous clear
   p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> det_q);
   // R6: a clear with no competing event empties the bit
   p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_evt) |=> !det_q);
   // R3: field 0 never latches
   p_code0_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_i[3:0] == 4'd0 && !det_q) |=> !det_q);
   // R4: edge-only modes do not re-latch without a transition
   p_edge_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_i[1:0] == 2'd0 && lvl_i == prev_q && !det_q) |=> !det_q);
endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
   import xirq_pkg::*;
#(
   parameter int NUM_IN = 4,
   parameter int ADDR_W = 9
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            reg_wr,
   input  logic [ADDR_W-1:0]               reg_addr,
   input  logic [DATA_W-1:0]               reg_wdata,
   output logic [DATA_W-1:0]               reg_rdata,
   input  logic [NUM_IN-1:0]               det_i,
   input  logic [NUM_IN-1:0]               lvl_i,
   output logic [NUM_IN-1:0]               en_o,
   output logic [NUM_IN-1:0]               det_clr_o,
   output logic [NUM_IN-1:0][SENSE_W-1:0]  sense_o
);
   localparam int IDX_W = 5;

   logic [NUM_IN-1:0]              en_q, set_mask, clr_mask;
   logic [NUM_IN-1:0][SENSE_W-1:0] cfg_q;
   logic                           cfg_hit;
   logic [IDX_W-1:0]               cfg_idx;
   logic                           unused_wdata;

   assign unused_wdata = ^reg_wdata;

   function automatic logic at(input logic [ADDR_W-1:0] a, input int off);
      return a == ADDR_W'(off);
   endfunction

   assign cfg_idx = reg_addr[IDX_W+1:2];
   assign cfg_hit = (reg_addr[1:0] == 2'b00) &&
                    ((reg_addr >> 7) == ADDR_W'(OFF_CFG_BASE >> 7)) &&
                    (int'(cfg_idx) < NUM_IN);

   assign set_mask  = (reg_wr && at(reg_addr, OFF_EN_SET)) ? reg_wdata[NUM_IN-1:0] : '0;
   assign clr_mask  = (reg_wr && at(reg_addr, OFF_EN_CLR)) ? reg_wdata[NUM_IN-1:0] : '0;
   assign det_clr_o = (reg_wr && at(reg_addr, OFF_DETECT)) ? reg_wdata[NUM_IN-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= (en_q | set_mask) & ~clr_mask;
   end

   for (genvar n = 0; n < NUM_IN; n++) begin : g_cfg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cfg_q[n] <= '0;
         else if (reg_wr && cfg_hit && int'(cfg_idx) == n)
            cfg_q[n] <= reg_wdata[SENSE_W-1:0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (cfg_hit)
         reg_rdata = DATA_W'(cfg_q[cfg_idx]);
      else if (at(reg_addr, OFF_REQ_STAT))
         reg_rdata = DATA_W'(det_i & en_q);
      else if (at(reg_addr, OFF_EN_CLR))
         reg_rdata = DATA_W'(en_q);
      else if (at(reg_addr, OFF_DETECT))
         reg_rdata = DATA_W'(det_i);
      else if (at(reg_addr, OFF_LEVEL))
         reg_rdata = DATA_W'(lvl_i);
   end

   assign en_o    = en_q;
   assign sense_o = cfg_q;

   // R7: set location raises every addressed bit
   p_en_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (set_mask != '0) |=> ((en_q & $past(set_mask)) == $past(set_mask)));
   // R7: clear location drops every addressed bit
   p_en_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask != '0) |=> ((en_q & $past(clr_mask)) == '0));
   // R1: write decodes are mutually exclusive
   p_one_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({|set_mask, |clr_mask, |det_clr_o}) <= 1);
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
   import xirq_pkg::*;
#(
   parameter int NUM_IN      = 32,
   parameter int ADDR_W      = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IN-1:0] pin_i,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic [NUM_IN-1:0] req_o
);
   if (NUM_IN < 1 || NUM_IN > 32) begin : g_bad_num
      $error("xirq_ctrl: NUM_IN must lie in 1..32");
   end
   if (ADDR_W < 9) begin : g_bad_addr
      $error("xirq_ctrl: ADDR_W must be at least 9");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("xirq_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [NUM_IN-1:0]              lvl, det, en, det_clr;
   logic [NUM_IN-1:0][SENSE_W-1:0] sense;

   xirq_sync #(.W(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_i),
      .q_o   (lvl)
   );

   xirq_regs #(.NUM_IN(NUM_IN), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .det_i     (det),
      .lvl_i     (lvl),
      .en_o      (en),
      .det_clr_o (det_clr),
      .sense_o   (sense)
   );

   for (genvar n = 0; n < NUM_IN; n++) begin : g_chan
      xirq_chan u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .lvl_i   (lvl[n]),
         .sense_i (sense[n]),
         .clr_i   (det_clr[n]),
         .en_i    (en[n]),
         .det_o   (det[n]),
         .req_o   (req_o[n])
      );

      // R10: a request needs the enable one edge earlier
      p_req_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
         req_o[n] |-> $past(en[n]));
      // R10: a request needs a latched event one edge earlier
      p_req_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
         req_o[n] |-> $past(det[n]));
   end
endmodule

// File: tb/test_xirq_ctrl.sv
module test_xirq_ctrl;
   localparam int N  = 4;
   localparam int AW = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pin = '0;
   logic          wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [N-1:0]  req;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   xirq_ctrl #(.NUM_IN(N), .ADDR_W(AW), .SYNC_STAGES(2)) i_xirq_ctrl (
      .clk(clk), .rst_n(rst_n), .pin_i(pin), .reg_wr(wr), .reg_addr(addr),
      .reg_wdata(wdata), .reg_rdata(rdata), .req_o(req)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input int a, input logic [31:0] d);
      @(negedge clk);
      wr = 1'b1; addr = AW'(a); wdata = d;
      @(negedge clk);
      wr = 1'b0; wdata = '0;
   endtask

   task automatic rd_reg(input int a, output logic [31:0] d);
      addr = AW'(a);
      #1;
      d = rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      logic [31:0] e;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12: reset state
      rd_reg('h000, v); chk("R12 request status", v, 0);
      rd_reg('h004, v); chk("R12 enable mask", v, 0);
      rd_reg('h100, v); chk("R12 detect word", v, 0);
      chk("R12 req_o", 32'(req), 0);
      for (int p = 0; p < N; p++) begin
         rd_reg('h180 + 4*p, v); chk("R12 config word", v, 0);
      end

      // R1: mask width, out-of-range config, unmapped offset
      wr_reg('h008, 32'hFFFF_FFFF);
      rd_reg('h004, v); chk("R1 R7 enable mask width", v, 32'h0000_000F);
      rd_reg('h008, v); chk("R7 set location reads 0", v, 0);
      wr_reg('h004, 32'h0000_0005);
      rd_reg('h004, v); chk("R7 clear by ones", v, 32'h0000_000A);
      wr_reg('h000, 32'hFFFF_FFFF);
      rd_reg('h004, v); chk("R8 write to request status ignored", v, 32'h0000_000A);
      wr_reg('h180 + 4*N, 32'h3F);
      rd_reg('h180 + 4*N, v); chk("R1 out-of-range config", v, 0);
      rd_reg('h00C, v); chk("R1 unmapped offset", v, 0);
      wr_reg('h004, 32'hFFFF_FFFF);

      // R3 R4 R5 R11 R2: sweep of every sense field on two pins
      for (int k = 0; k < 2; k++) begin
         automatic int p = (k == 0) ? 0 : N - 1;
         for (int c = 0; c < 64; c++) begin
            automatic logic [5:0] cd = 6'(c);
            @(negedge clk); pin[p] = 1'b0;
            wr_reg('h180 + 4*p, 32'hFFFF_FFC0 | 32'(c));
            rd_reg('h180 + 4*p, v); chk("R2 config readback", v, 32'(c));
            idle(5);
            wr_reg('h100, 32'hFFFF_FFFF); idle(4);
            rd_reg('h100, v); e = 32'(cd[0]) << p;
            chk("R3 R5 R11 held low after clear", v, e);
            @(negedge clk); pin[p] = 1'b1; idle(5);
            rd_reg('h100, v); e = 32'(cd[0] | cd[1] | cd[3]) << p;
            chk("R3 rising phase", v, e);
            wr_reg('h100, 32'hFFFF_FFFF); idle(4);
            rd_reg('h100, v); e = 32'(cd[1]) << p;
            chk("R4 R5 R11 held high after clear", v, e);
            @(negedge clk); pin[p] = 1'b0; idle(5);
            rd_reg('h100, v); e = 32'(cd[0] | cd[1] | cd[2]) << p;
            chk("R3 falling phase", v, e);
            wr_reg('h100, 32'hFFFF_FFFF); idle(4);
            rd_reg('h100, v); e = 32'(cd[0]) << p;
            chk("R4 R5 low again after clear", v, e);
            wr_reg('h180 + 4*p, 0);
            wr_reg('h100, 32'hFFFF_FFFF); idle(4);
            rd_reg('h100, v); chk("R3 field 0 silent", v, 0);
         end
      end
      wr_reg('h004, 32'hFFFF_FFFF);

      // R4 R9 R10: latency of a rising edge on pin 1
      wr_reg('h180 + 4*1, 32'h08);
      wr_reg('h008, 32'h2);
      @(negedge clk); pin[1] = 1'b1;
      @(negedge clk);
      rd_reg('h104, v); chk("R9 level after one edge", v, 0);
      @(negedge clk);
      rd_reg('h104, v); chk("R9 level after two edges", v, 32'h2);
      rd_reg('h100, v); chk("R4 detect after two edges", v, 0);
      @(negedge clk);
      rd_reg('h100, v); chk("R4 detect after three edges", v, 32'h2);
      chk("R10 req one edge behind", 32'(req), 0);
      rd_reg('h000, v); chk("R8 request status", v, 32'h2);
      @(negedge clk);
      chk("R10 req after four edges", 32'(req), 32'h2);

      // R10 R8: disable drops request status at once and req_o one edge later
      wr_reg('h004, 32'h2);
      chk("R10 req held one edge after disable", 32'(req), 32'h2);
      rd_reg('h000, v); chk("R8 status after disable", v, 0);
      @(negedge clk);
      chk("R10 req after disable", 32'(req), 0);

      // R6: writing zeros keeps, writing ones clears
      wr_reg('h100, 32'h0);
      rd_reg('h100, v); chk("R6 write zero keeps", v, 32'h2);
      wr_reg('h100, 32'h2);
      rd_reg('h100, v); chk("R6 write one clears", v, 0);

      // R11: clear while high level is held leaves the bit set
      wr_reg('h180 + 4*2, 32'h02);
      @(negedge clk); pin[2] = 1'b1; idle(5);
      wr_reg('h100, 32'h4);
      rd_reg('h100, v); chk("R11 set beats clear", v, 32'h4);
      @(negedge clk); pin[2] = 1'b0; idle(5);
      wr_reg('h100, 32'h4); idle(2);
      rd_reg('h100, v); chk("R5 clear sticks after release", v, 0);

      finish_run();
   end
endmodule